// File: doc/BRIEF.md
# Programmable I2C SCL Timing Generator

This block produces the serial clock of an I2C master and the per-bit timing points that a byte engine needs to move SDA. It runs from one fixed internal clock and counts four programmed quantities: the whole SCL period, the length of the low phase, the setup time for a repeated start or stop condition, and the data setup time before each SCL rising edge. Typical settings are a period of reference-clock frequency divided by bus rate, a low phase and condition setup of half the period, and a data setup of one sixteenth of the period. The fastest intended bus rate is 400 kHz, which is a period of 125 clocks at a 50 MHz reference.

A two-bit bus control register gates the generator. Its upper bit enables normal operation and its lower bit releases SCL. While normal operation is off, the timing inputs are copied into an internal shadow, the counters sit at zero and the strobes are silent. SCL then keeps its last level, so a low SCL stays low until the release bit lets it go. While normal operation is on, the shadow is frozen. The byte engine raises a start or stop request and gets a strobe at the condition point of the next high phase.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_drv_low` is 0 (SCL released), all four strobes are 0, and the control register holds 0.
- R2: Normal operation starts on the clock edge that writes 1 to control bit 1. From the next cycle, `scl_drv_low` is 1 for L cycles and then 0 for H = P - L cycles, and this repeats. P is the effective period and L the effective low count.
- R3: Clamping: P is `period_cnt`, or 2 when `period_cnt` is below 2. L is 1 when `low_cnt` is 0, P-1 when `low_cnt` is at least P, and `low_cnt` otherwise. Both phases therefore last at least one cycle.
- R4: `chg_stb` pulses once per low phase, exactly D cycles before the cycle in which `scl_drv_low` falls to 0. D is `dsu_cnt`, forced to at least 1 and at most L.
- R5: `smp_stb` pulses once per high phase, in high-phase cycle floor(H/2), counting that phase's first cycle as 0.
- R6: In each high phase, the condition point is high-phase cycle min(`rsu_cnt`, H-1). At that point `stop_stb` pulses if `stop_req` is high; otherwise `start_stb` pulses if `start_req` is high. The two strobes are never high together.
- R7: The timing inputs are captured only while control bit 1 is 0. Changing them while the generator runs does not alter SCL or the strobes.
- R8: Writing 0 to control bit 1 stops the generator on that edge: the counters return to zero and no strobe fires. With control bit 0 also 0, `scl_drv_low` keeps the value it had before the write.
- R9: While control bit 1 is 0 and control bit 0 is 1, `scl_drv_low` is 0 from the cycle after the write.
- R10: The control register changes only on an edge where `ctl_we` is 1, taking `ctl_wdata` (bit 1 = enable, bit 0 = release). A write of both bits set runs the generator normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Write strobe for the bus control register |
| ctl_wdata | input | 2 | Control value: bit 1 enable, bit 0 release SCL |
| period_cnt | input | CW | Full SCL period in clocks |
| low_cnt | input | CW | SCL low-phase length in clocks |
| rsu_cnt | input | CW | Setup count for repeated start or stop, from the rising edge |
| dsu_cnt | input | CW | Data setup count before the rising edge |
| start_req | input | 1 | Byte engine asks for a start condition |
| stop_req | input | 1 | Byte engine asks for a stop condition |
| scl_drv_low | output | 1 | 1 = pull SCL low, 0 = release |
| chg_stb | output | 1 | SDA may change in this cycle |
| smp_stb | output | 1 | Sample SDA in this cycle |
| start_stb | output | 1 | Drive the start condition edge on SDA |
| stop_stb | output | 1 | Drive the stop condition edge on SDA |

## Verification
The generator is run with a balanced half-period setting, with a short low phase and a long data setup, with low and setup counts that hit every clamp, with the smallest legal period, and with a 400 kHz setting. Each pattern separates the phase lengths from the strobe offsets: a wrong clamp moves the rising edge, while a wrong offset moves only one strobe. One run changes the timing inputs while the generator runs, to show they are ignored. Direct checks stop the generator during a low phase, which separates frozen-low from released behaviour, and confirm that control data without a write strobe is ignored.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  // Phase of the serial clock as seen by the counters.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  // Field positions of the bus control register.
  localparam int unsigned CTL_W   = 2;
  localparam int unsigned CTL_EN  = 1;
  localparam int unsigned CTL_REL = 0;
endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [CW-1:0] period_cnt,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] rsu_cnt,
  input  logic [CW-1:0] dsu_cnt,
  output logic [CW-1:0] lo_last,
  output logic [CW-1:0] hi_last,
  output logic [CW-1:0] chg_pt,
  output logic [CW-1:0] smp_pt,
  output logic [CW-1:0] cnd_pt
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] p_c, l_c, h_c, d_c;
  logic [CW-1:0] lo_last_d, hi_last_d, chg_pt_d, smp_pt_d, cnd_pt_d;

  // Clamp the programmed counts and derive the in-phase trigger points.
  always_comb begin
    p_c = (period_cnt < TWO) ? TWO : period_cnt;
    if (low_cnt == '0)
      l_c = ONE;
    else if (low_cnt >= p_c)
      l_c = p_c - ONE;
    else
      l_c = low_cnt;
    h_c = p_c - l_c;
    if (dsu_cnt == '0)
      d_c = ONE;
    else if (dsu_cnt > l_c)
      d_c = l_c;
    else
      d_c = dsu_cnt;
    lo_last_d = l_c - ONE;
    hi_last_d = h_c - ONE;
    chg_pt_d  = l_c - d_c;
    smp_pt_d  = h_c >> 1;
    cnd_pt_d  = (rsu_cnt >= h_c) ? (h_c - ONE) : rsu_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_last <= '0;
      hi_last <= '0;
      chg_pt  <= '0;
      smp_pt  <= '0;
      cnd_pt  <= '0;
    end else if (capture) begin
      lo_last <= lo_last_d;
      hi_last <= hi_last_d;
      chg_pt  <= chg_pt_d;
      smp_pt  <= smp_pt_d;
      cnd_pt  <= cnd_pt_d;
    end
  end

  // R7
  shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(lo_last) && $stable(hi_last) && $stable(chg_pt)
                  && $stable(smp_pt) && $stable(cnd_pt)));

  // R4
  chg_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capture) |-> (chg_pt <= lo_last));

  // R6
  cnd_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capture) |-> (cnd_pt <= hi_last && smp_pt <= hi_last));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import i2c_scl_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_now,
  input  logic          run_nxt,
  input  logic          rel_nxt,
  input  logic [CW-1:0] lo_last,
  input  logic [CW-1:0] hi_last,
  output scl_phase_e    phase_q,
  output logic [CW-1:0] cnt_q,
  output logic          scl_low_q
);
  scl_phase_e    phase_d;
  logic [CW-1:0] cnt_d;
  logic          scl_low_d;

  // Next state: stopped, starting, or advancing through the phases.
  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    scl_low_d = scl_low_q;
    if (!run_nxt) begin
      phase_d   = PH_LOW;
      cnt_d     = '0;
      scl_low_d = rel_nxt ? 1'b0 : scl_low_q;
    end else if (!run_now) begin
      phase_d   = PH_LOW;
      cnt_d     = '0;
      scl_low_d = 1'b1;
    end else if (phase_q == PH_LOW && cnt_q == lo_last) begin
      phase_d   = PH_HIGH;
      cnt_d     = '0;
      scl_low_d = 1'b0;
    end else if (phase_q == PH_HIGH && cnt_q == hi_last) begin
      phase_d   = PH_LOW;
      cnt_d     = '0;
      scl_low_d = 1'b1;
    end else begin
      cnt_d     = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_LOW;
      cnt_q     <= '0;
      scl_low_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      scl_low_q <= scl_low_d;
    end
  end

  // R2
  low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && phase_q == PH_LOW) |-> (cnt_q <= lo_last));

  // R2
  high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && phase_q == PH_HIGH) |-> (cnt_q <= hi_last));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_now |-> (cnt_q == '0 && phase_q == PH_LOW));
endmodule

// File: rtl/scl_strobe_dec.sv
module scl_strobe_dec
  import i2c_scl_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          run,
  input  scl_phase_e    phase,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] chg_pt,
  input  logic [CW-1:0] smp_pt,
  input  logic [CW-1:0] cnd_pt,
  input  logic          start_req,
  input  logic          stop_req,
  output logic          chg_stb,
  output logic          smp_stb,
  output logic          start_stb,
  output logic          stop_stb
);
  logic in_low, in_high, at_cnd;

  always_comb begin
    in_low    = run && (phase == PH_LOW);
    in_high   = run && (phase == PH_HIGH);
    at_cnd    = in_high && (cnt == cnd_pt);
    chg_stb   = in_low && (cnt == chg_pt);
    smp_stb   = in_high && (cnt == smp_pt);
    stop_stb  = at_cnd && stop_req;
    start_stb = at_cnd && start_req && !stop_req;
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_wdata,
  input  logic [CW-1:0] period_cnt,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] rsu_cnt,
  input  logic [CW-1:0] dsu_cnt,
  input  logic          start_req,
  input  logic          stop_req,
  output logic          scl_drv_low,
  output logic          chg_stb,
  output logic          smp_stb,
  output logic          start_stb,
  output logic          stop_stb
);
  logic             rst_s1, rst_s2;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [CW-1:0]    lo_last, hi_last, chg_pt, smp_pt, cnd_pt;
  scl_phase_e       phase_q;
  logic [CW-1:0]    cnt_q;

  // Asynchronous assertion, synchronous release of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  // Bus control register.
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we)
      ctl_d = ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2)
      ctl_q <= '0;
    else
      ctl_q <= ctl_d;
  end

  scl_cfg_shadow #(.CW(CW)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_s2),
    .capture    (!ctl_q[CTL_EN]),
    .period_cnt (period_cnt),
    .low_cnt    (low_cnt),
    .rsu_cnt    (rsu_cnt),
    .dsu_cnt    (dsu_cnt),
    .lo_last    (lo_last),
    .hi_last    (hi_last),
    .chg_pt     (chg_pt),
    .smp_pt     (smp_pt),
    .cnd_pt     (cnd_pt)
  );

  scl_phase_ctr #(.CW(CW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_s2),
    .run_now   (ctl_q[CTL_EN]),
    .run_nxt   (ctl_d[CTL_EN]),
    .rel_nxt   (ctl_d[CTL_REL]),
    .lo_last   (lo_last),
    .hi_last   (hi_last),
    .phase_q   (phase_q),
    .cnt_q     (cnt_q),
    .scl_low_q (scl_drv_low)
  );

  scl_strobe_dec #(.CW(CW)) u_dec (
    .run       (ctl_q[CTL_EN]),
    .phase     (phase_q),
    .cnt       (cnt_q),
    .chg_pt    (chg_pt),
    .smp_pt    (smp_pt),
    .cnd_pt    (cnd_pt),
    .start_req (start_req),
    .stop_req  (stop_req),
    .chg_stb   (chg_stb),
    .smp_stb   (smp_stb),
    .start_stb (start_stb),
    .stop_stb  (stop_stb)
  );

  // R4
  chg_while_low_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    chg_stb |-> scl_drv_low);

  // R5
  smp_while_high_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (smp_stb || start_stb || stop_stb) |-> !scl_drv_low);

  // R6
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    $onehot0({start_stb, stop_stb}));

  // R8
  frozen_scl_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (ctl_q == 2'b00) |-> $stable(scl_drv_low));

  // R9
  released_scl_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (ctl_q == 2'b01) |-> !scl_drv_low);

  // R8
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    !ctl_q[CTL_EN] |-> !(chg_stb || smp_stb || start_stb || stop_stb));

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    !$past(ctl_we) |-> $stable(ctl_q));
endmodule

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [1:0]    ctl_wdata = 2'b00;
  logic [CW-1:0] period_cnt = '0, low_cnt = '0, rsu_cnt = '0, dsu_cnt = '0;
  logic          start_req = 1'b0, stop_req = 1'b0;
  logic          scl_drv_low, chg_stb, smp_stb, start_stb, stop_stb;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  logic prev_scl = 1'b0;

  typedef struct {
    int kind;   // 0 SCL pulled low, 1 SCL released, 2 chg, 3 smp, 4 start, 5 stop
    int at;
    int rq;
  } ev_t;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_scl_timer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .period_cnt(period_cnt), .low_cnt(low_cnt), .rsu_cnt(rsu_cnt),
    .dsu_cnt(dsu_cnt), .start_req(start_req), .stop_req(stop_req),
    .scl_drv_low(scl_drv_low), .chg_stb(chg_stb), .smp_stb(smp_stb),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input int rq);
    ev_t e;
    e.kind = kind; e.at = at; e.rq = rq;
    exp_q.push_back(e);
  endtask

  // Monitor: pops the expected item for every observed event.
  task automatic got(input int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL unexpected event actual=kind%0d@%0d expected=none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        failures++;
        $display("FAIL R%0d actual=kind%0d@%0d expected=kind%0d@%0d",
                 e.rq, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_drv_low && !prev_scl) got(0);
      if (!scl_drv_low && prev_scl) got(1);
      if (chg_stb)   got(2);
      if (smp_stb)   got(3);
      if (start_stb) got(4);
      if (stop_stb)  got(5);
    end
    prev_scl = scl_drv_low;
  end

  // Driver: computes the expected schedule from the requirements, then runs it.
  task automatic run_case(input int per, input int low, input int rsu, input int dsu,
                          input int nper, input bit sreq, input bit preq,
                          input bit poke, input logic [1:0] on_val, input int ph_rq);
    int p, l, h, d, cnd, c, base, t;
    p = (per < 2) ? 2 : per;                       // R3
    l = (low == 0) ? 1 : ((low >= p) ? p - 1 : low);
    h = p - l;
    d = (dsu == 0) ? 1 : ((dsu > l) ? l : dsu);    // R4
    cnd = (rsu >= h) ? h - 1 : rsu;                // R6
    period_cnt = CW'(per); low_cnt = CW'(low);
    rsu_cnt = CW'(rsu); dsu_cnt = CW'(dsu);
    start_req = sreq; stop_req = preq;
    @(negedge clk);
    c = cyc;
    for (int k = 0; k < nper * p; k++) begin
      t = k % p;
      base = c + 1 + k;
      if (t == 0) push(0, base, ph_rq);
      if (t == l) push(1, base, ph_rq);
      if (t == l - d) push(2, base, 4);
      if (t == l + h / 2) push(3, base, 5);
      if (t == l + cnd) begin
        if (preq) push(5, base, 6);
        else if (sreq) push(4, base, 6);
      end
    end
    ctl_we = 1'b1; ctl_wdata = on_val;
    @(negedge clk);
    ctl_we = 1'b0;
    if (poke) begin  // R7: changes while running must be ignored
      period_cnt = CW'(40); low_cnt = CW'(3); rsu_cnt = CW'(1); dsu_cnt = CW'(2);
    end
    repeat (nper * p - 1) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 2'b01;
    @(negedge clk);
    ctl_we = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 pending events", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(scl_drv_low == 1'b0, "R1 scl", scl_drv_low, 0);
    check({chg_stb, smp_stb, start_stb, stop_stb} == 4'b0, "R1 strobes",
          {chg_stb, smp_stb, start_stb, stop_stb}, 0);
    mon_on = 1'b1;

    run_case(10, 5, 5, 1, 3, 1'b1, 1'b0, 1'b0, 2'b10, 2);   // R2 R4 R5 R6 balanced
    run_case(20, 6, 3, 4, 2, 1'b0, 1'b1, 1'b0, 2'b10, 2);   // R6 stop
    run_case(9, 0, 20, 0, 2, 1'b1, 1'b1, 1'b0, 2'b10, 3);   // R3 low=0, R6 clamp + priority
    run_case(12, 30, 0, 50, 3, 1'b1, 1'b0, 1'b0, 2'b10, 3); // R3 low>=period, R4 clamp
    run_case(1, 5, 3, 3, 4, 1'b0, 1'b0, 1'b0, 2'b10, 3);    // R3 minimum period
    run_case(16, 8, 4, 2, 3, 1'b1, 1'b0, 1'b1, 2'b10, 7);   // R7 shadow
    run_case(125, 62, 62, 7, 2, 1'b0, 1'b1, 1'b0, 2'b11, 10); // R10 both bits, 400 kHz

    // R8 / R9 / R10 direct: stop during a low phase
    mon_on = 1'b0;
    period_cnt = CW'(10); low_cnt = CW'(5); rsu_cnt = CW'(2); dsu_cnt = CW'(1);
    start_req = 1'b1; stop_req = 1'b0;
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 2'b10;
    @(negedge clk); ctl_we = 1'b0;
    check(scl_drv_low == 1'b1, "R2 first low cycle", scl_drv_low, 1);
    ctl_we = 1'b1; ctl_wdata = 2'b00;
    @(negedge clk); ctl_we = 1'b0;
    ctl_wdata = 2'b10;  // R10: no write strobe, must be ignored
    for (int i = 0; i < 6; i++) begin
      check(scl_drv_low == 1'b1, "R8 frozen low", scl_drv_low, 1);
      check({chg_stb, smp_stb, start_stb, stop_stb} == 4'b0, "R8 quiet",
            {chg_stb, smp_stb, start_stb, stop_stb}, 0);
      @(negedge clk);
    end
    check(scl_drv_low == 1'b1, "R10 no write", scl_drv_low, 1);
    ctl_we = 1'b1; ctl_wdata = 2'b01;
    @(negedge clk); ctl_we = 1'b0;
    check(scl_drv_low == 1'b0, "R9 released", scl_drv_low, 0);
    ctl_we = 1'b1; ctl_wdata = 2'b00;
    @(negedge clk); ctl_we = 1'b0;
    repeat (3) @(negedge clk);
    check(scl_drv_low == 1'b0, "R8 frozen high", scl_drv_low, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule